// File: doc/BRIEF.md
# Banked CPU Register File

This block is the programmer-visible register storage of an 8-bit processor core. It holds six general byte registers, G0 to G5, which can also be used as three 16-bit pairs. It holds an accumulator and a flags byte. Each of these exists twice, in a primary bank and a shadow bank. Outside the banks sit a 16-bit stack pointer, two 16-bit index registers, an interrupt page byte and a refresh counter byte. The decoder and the ALU around the block drive its ports. The block provides two byte read ports, one 16-bit pair read port, a byte write port and a pair write port.

Two exchange strobes swap banks without moving any data. One strobe flips the select bit for the accumulator/flags bank. The other flips the select bit shared by all six general registers. Every read and write addresses whichever bank is currently selected. A fetch strobe advances the refresh counter once for each opcode fetch.

Top module: `banked_regfile`

## Requirements
- R1: Byte codes are 0..5 = G0..G5, 6 = flags, 7 = accumulator. A byte write lands in the selected bank at the next clock edge. Both byte read ports show the addressed register of the selected bank combinationally.
- R2: Pair codes 0, 1 and 2 are G0:G1, G2:G3 and G4:G5, and pair code 3 is accumulator:flags. In each pair the first register is the high byte. A pair write updates both bytes in one clock, and the pair read port returns them in the same order.
- R3: Pair code 4 is the stack pointer, 5 is index X, 6 is index Y, and 7 is {page, refresh}. Each of these is written and read whole through the pair ports.
- R4: A pulse on xchg_gen flips the general-register bank select. The contents of the other bank are kept and reappear after a second flip.
- R5: A pulse on xchg_acc flips the accumulator/flags bank select. It has no effect on the general registers, and xchg_gen has no effect on the accumulator/flags bank.
- R6: The stack pointer, the index registers, the page register and the refresh register do not change on either exchange.
- R7: Each fetch pulse adds one to refresh bits 6:0, wrapping 7F to 00, and leaves bit 7 unchanged.
- R8: When a pair write to code 7 and a fetch pulse occur in the same cycle, the written value is stored.
- R9: A read of a register in the same cycle as a write to it returns the old value.
- R10: When the byte and pair ports write the same register in one cycle, the pair write wins. A write in the same cycle as an exchange goes to the bank that was selected before the flip.
- R11: Reset clears both select bits, every banked register, both index registers, the page register and the refresh register, and sets the stack pointer to FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_sel | input | 3 | Byte read port A code |
| ra_data | output | 8 | Byte read port A data |
| rb_sel | input | 3 | Byte read port B code |
| rb_data | output | 8 | Byte read port B data |
| pr_sel | input | 3 | Pair read code |
| pr_data | output | 16 | Pair read data |
| bw_en | input | 1 | Byte write enable |
| bw_sel | input | 3 | Byte write code |
| bw_data | input | 8 | Byte write data |
| pw_en | input | 1 | Pair write enable |
| pw_sel | input | 3 | Pair write code |
| pw_data | input | 16 | Pair write data |
| xchg_gen | input | 1 | Flip general-register bank select |
| xchg_acc | input | 1 | Flip accumulator/flags bank select |
| fetch_tick | input | 1 | Opcode fetch pulse for the refresh counter |
| gen_bank | output | 1 | Current general bank select |
| acc_bank | output | 1 | Current accumulator/flags bank select |

## Verification
A vector table writes a distinct word to every pair code and reads it back through both the pair port and the byte ports. This shows whether the high and low bytes are ordered correctly and whether the codes decode to separate registers. Exchange sequences load different values into the two banks and toggle each strobe alone. These show whether the two selects are really independent and whether the hidden bank is left untouched. Refresh patterns start from 7E and from FF to separate the wrap of the low seven bits from a carry into bit 7. Same-cycle collisions of byte and pair writes, write and exchange, and write and fetch pin down the priority rules.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DW = 8;
  localparam int PW = 2 * DW;
  localparam int NGEN = 6;
  localparam int NACC = 2;

  // byte codes
  localparam logic [2:0] BY_FLAGS = 3'd6;
  localparam logic [2:0] BY_ACC   = 3'd7;

  // pair codes
  localparam logic [2:0] PR_ACCF = 3'd3;
  localparam logic [2:0] PR_SP   = 3'd4;
  localparam logic [2:0] PR_IX   = 3'd5;
  localparam logic [2:0] PR_IY   = 3'd6;
  localparam logic [2:0] PR_PGRF = 3'd7;

  localparam logic [PW-1:0] SP_RESET = '1;

  // refresh step: low seven bits count, top bit held
  function automatic logic [DW-1:0] refresh_step(input logic [DW-1:0] r);
    logic [DW-2:0] low;
    low = r[DW-2:0] + 1'b1;
    return {r[DW-1], low};
  endfunction
endpackage

// File: rtl/bank_store.sv
module bank_store #(
  parameter int NREG = 6,
  parameter int W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xchg,
  input  logic [NREG-1:0]          wr_en,
  input  logic [NREG-1:0][W-1:0]   wr_data,
  output logic [NREG-1:0][W-1:0]   act_q,
  output logic [NREG-1:0][W-1:0]   idle_q,
  output logic                     sel_q
);
  logic [1:0][NREG-1:0][W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      if (xchg) sel_q <= ~sel_q;
      for (int i = 0; i < NREG; i++)
        if (wr_en[i]) store_q[sel_q][i] <= wr_data[i];
    end
  end

  assign act_q  = store_q[sel_q];
  assign idle_q = store_q[~sel_q];

  // R4
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg |=> sel_q != $past(sel_q));
  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg |=> $stable(sel_q));
  // R4
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg |=> $stable(idle_q));
endmodule

// File: rtl/ptr_regs.sv
module ptr_regs
  import regfile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sp,
  input  logic          wr_ix,
  input  logic          wr_iy,
  input  logic          wr_pgrf,
  input  logic [PW-1:0] wr_data,
  input  logic          fetch_tick,
  output logic [PW-1:0] sp_q,
  output logic [PW-1:0] ix_q,
  output logic [PW-1:0] iy_q,
  output logic [DW-1:0] page_q,
  output logic [DW-1:0] rfsh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q   <= SP_RESET;
      ix_q   <= '0;
      iy_q   <= '0;
      page_q <= '0;
      rfsh_q <= '0;
    end else begin
      if (wr_sp) sp_q <= wr_data;
      if (wr_ix) ix_q <= wr_data;
      if (wr_iy) iy_q <= wr_data;
      if (wr_pgrf) begin
        page_q <= wr_data[PW-1:DW];
        rfsh_q <= wr_data[DW-1:0];
      end else if (fetch_tick) begin
        rfsh_q <= refresh_step(rfsh_q);
      end
    end
  end

  // R7
  rfsh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_tick && !wr_pgrf) |=>
      (rfsh_q[DW-1] == $past(rfsh_q[DW-1])) &&
      (rfsh_q[DW-2:0] == $past(rfsh_q[DW-2:0]) + 1'b1));
  // R8
  rfsh_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pgrf |=> rfsh_q == $past(wr_data[DW-1:0]));
  // R6
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sp |=> $stable(sp_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ra_sel,
  output logic [DW-1:0] ra_data,
  input  logic [2:0]    rb_sel,
  output logic [DW-1:0] rb_data,
  input  logic [2:0]    pr_sel,
  output logic [PW-1:0] pr_data,
  input  logic          bw_en,
  input  logic [2:0]    bw_sel,
  input  logic [DW-1:0] bw_data,
  input  logic          pw_en,
  input  logic [2:0]    pw_sel,
  input  logic [PW-1:0] pw_data,
  input  logic          xchg_gen,
  input  logic          xchg_acc,
  input  logic          fetch_tick,
  output logic          gen_bank,
  output logic          acc_bank
);
  logic [NGEN-1:0]          gen_we;
  logic [NGEN-1:0][DW-1:0]  gen_wd, gen_q, gen_idle;
  logic [NACC-1:0]          acc_we;
  logic [NACC-1:0][DW-1:0]  acc_wd, acc_q, acc_idle;
  logic [PW-1:0]            sp_q, ix_q, iy_q;
  logic [DW-1:0]            page_q, rfsh_q;
  logic                     pw_gen_hit, pw_acc_hit;

  assign pw_gen_hit = pw_en && (pw_sel < PR_ACCF);
  assign pw_acc_hit = pw_en && (pw_sel == PR_ACCF);

  // Write steering: byte port first, pair port overrides
  always_comb begin
    gen_we = '0;
    gen_wd = '0;
    acc_we = '0;
    acc_wd = '0;
    if (bw_en) begin
      if (bw_sel < BY_FLAGS) begin
        gen_we[bw_sel] = 1'b1;
        gen_wd[bw_sel] = bw_data;
      end else begin
        acc_we[bw_sel[0]] = 1'b1;
        acc_wd[bw_sel[0]] = bw_data;
      end
    end
    if (pw_gen_hit) begin
      gen_we[{pw_sel[1:0], 1'b0}] = 1'b1;
      gen_wd[{pw_sel[1:0], 1'b0}] = pw_data[PW-1:DW];
      gen_we[{pw_sel[1:0], 1'b1}] = 1'b1;
      gen_wd[{pw_sel[1:0], 1'b1}] = pw_data[DW-1:0];
    end
    if (pw_acc_hit) begin
      acc_we = '1;
      acc_wd[1] = pw_data[PW-1:DW];
      acc_wd[0] = pw_data[DW-1:0];
    end
  end

  bank_store #(.NREG(NGEN), .W(DW)) u_gen (
    .clk(clk), .rst_n(rst_n), .xchg(xchg_gen),
    .wr_en(gen_we), .wr_data(gen_wd),
    .act_q(gen_q), .idle_q(gen_idle), .sel_q(gen_bank)
  );

  bank_store #(.NREG(NACC), .W(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .xchg(xchg_acc),
    .wr_en(acc_we), .wr_data(acc_wd),
    .act_q(acc_q), .idle_q(acc_idle), .sel_q(acc_bank)
  );

  ptr_regs u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_sp  (pw_en && pw_sel == PR_SP),
    .wr_ix  (pw_en && pw_sel == PR_IX),
    .wr_iy  (pw_en && pw_sel == PR_IY),
    .wr_pgrf(pw_en && pw_sel == PR_PGRF),
    .wr_data(pw_data), .fetch_tick(fetch_tick),
    .sp_q(sp_q), .ix_q(ix_q), .iy_q(iy_q),
    .page_q(page_q), .rfsh_q(rfsh_q)
  );

  function automatic logic [DW-1:0] byte_pick(
    input logic [2:0] code,
    input logic [NGEN-1:0][DW-1:0] g,
    input logic [NACC-1:0][DW-1:0] a);
    if (code < BY_FLAGS) return g[code];
    return a[code[0]];
  endfunction

  assign ra_data = byte_pick(ra_sel, gen_q, acc_q);
  assign rb_data = byte_pick(rb_sel, gen_q, acc_q);

  always_comb begin
    case (pr_sel)
      PR_ACCF: pr_data = {acc_q[1], acc_q[0]};
      PR_SP:   pr_data = sp_q;
      PR_IX:   pr_data = ix_q;
      PR_IY:   pr_data = iy_q;
      PR_PGRF: pr_data = {page_q, rfsh_q};
      default: pr_data = {gen_q[{pr_sel[1:0], 1'b0}], gen_q[{pr_sel[1:0], 1'b1}]};
    endcase
  end

  // R2
  pair_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && pw_sel == 3'd0 && !xchg_gen) |=> {gen_q[0], gen_q[1]} == $past(pw_data));
  // R10
  pair_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && bw_en && pw_sel == PR_ACCF && bw_sel == BY_ACC && !xchg_acc)
      |=> acc_q[1] == $past(pw_data[PW-1:DW]));
  // R5
  acc_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bw_en && !pw_en && !xchg_acc) |=> $stable(acc_q));
  // R6
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pw_en && (xchg_gen || xchg_acc)) |=> $stable(ix_q) && $stable(iy_q) && $stable(page_q));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] ra_sel, rb_sel, pr_sel, bw_sel, pw_sel;
  logic [7:0] ra_data, rb_data, bw_data;
  logic [15:0] pr_data, pw_data;
  logic bw_en, pw_en, xchg_gen, xchg_acc, fetch_tick, gen_bank, acc_bank;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .ra_sel(ra_sel), .ra_data(ra_data), .rb_sel(rb_sel), .rb_data(rb_data),
    .pr_sel(pr_sel), .pr_data(pr_data),
    .bw_en(bw_en), .bw_sel(bw_sel), .bw_data(bw_data),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
    .xchg_gen(xchg_gen), .xchg_acc(xchg_acc), .fetch_tick(fetch_tick),
    .gen_bank(gen_bank), .acc_bank(acc_bank)
  );

  // {pair code, data}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'h1234}, {3'd1, 16'h5678}, {3'd2, 16'h9ABC}, {3'd3, 16'hDEF0},
    {3'd4, 16'h0F1E}, {3'd5, 16'h2D3C}, {3'd6, 16'h4B5A}, {3'd7, 16'h6978}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bw_en = 0; pw_en = 0; xchg_gen = 0; xchg_acc = 0; fetch_tick = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic pwr(input logic [2:0] s, input logic [15:0] d);
    pw_en = 1; pw_sel = s; pw_data = d;
  endtask

  task automatic rd_pair(input logic [2:0] s, input string req, input logic [15:0] exp);
    pr_sel = s; #1;
    chk(req, pr_data, exp);
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ra_sel = 0; rb_sel = 0; pr_sel = 0; bw_sel = 0; pw_sel = 0;
    bw_data = 0; pw_data = 0;
    do_reset();

    // R11 reset state
    rd_pair(3'd4, "R11 sp", 16'hFFFF);
    rd_pair(3'd7, "R11 page/refresh", 16'h0000);
    rd_pair(3'd0, "R11 pair0", 16'h0000);
    rd_pair(3'd5, "R11 ix", 16'h0000);
    chk("R11 selects", {14'd0, gen_bank, acc_bank}, 16'h0000);

    // R2 R3 vector table
    for (int i = 0; i < 8; i++) begin
      pwr(VEC[i][18:16], VEC[i][15:0]);
      tick();
      rd_pair(VEC[i][18:16], "R2/R3 pair readback", VEC[i][15:0]);
      if (VEC[i][18:16] < 3'd3) begin
        ra_sel = {VEC[i][17:16], 1'b0}; rb_sel = {VEC[i][17:16], 1'b1}; #1;
        chk("R2 high byte order", {8'd0, ra_data}, {8'd0, VEC[i][15:8]});
        chk("R2 low byte order", {8'd0, rb_data}, {8'd0, VEC[i][7:0]});
      end
    end
    ra_sel = 3'd7; rb_sel = 3'd6; #1;
    chk("R1 accumulator code 7", {8'd0, ra_data}, 16'h00DE);
    chk("R1 flags code 6", {8'd0, rb_data}, 16'h00F0);

    // R1 byte write, R9 no write-through
    bw_en = 1; bw_sel = 3'd5; bw_data = 8'h3C; ra_sel = 3'd5; #1;
    chk("R9 old value during write", {8'd0, ra_data}, 16'h00BC);
    tick();
    chk("R1 byte write G5", {8'd0, ra_data}, 16'h003C);
    rd_pair(3'd2, "R1 pair sees byte write", 16'h9A3C);

    // R4 general exchange
    do_reset();
    pwr(3'd0, 16'h1111); tick();
    xchg_gen = 1; tick();
    chk("R4 gen select flipped", {15'd0, gen_bank}, 16'h0001);
    rd_pair(3'd0, "R4 shadow bank empty", 16'h0000);
    pwr(3'd0, 16'h2222); tick();
    xchg_gen = 1; tick();
    rd_pair(3'd0, "R4 primary kept", 16'h1111);
    xchg_gen = 1; tick();
    rd_pair(3'd0, "R4 shadow kept", 16'h2222);
    xchg_gen = 1; tick();

    // R5 accumulator exchange independent
    pwr(3'd3, 16'hA55A); tick();
    xchg_acc = 1; tick();
    chk("R5 acc select", {14'd0, gen_bank, acc_bank}, 16'h0001);
    rd_pair(3'd3, "R5 shadow acc empty", 16'h0000);
    rd_pair(3'd0, "R5 general unaffected", 16'h1111);
    xchg_gen = 1; tick();
    xchg_gen = 1; tick();
    xchg_acc = 1; tick();
    rd_pair(3'd3, "R5 acc back", 16'hA55A);

    // R6 pointers not banked
    pwr(3'd5, 16'hBEEF); tick();
    pwr(3'd7, 16'h4321); tick();
    xchg_gen = 1; xchg_acc = 1; tick();
    rd_pair(3'd4, "R6 sp after exchange", 16'hFFFF);
    rd_pair(3'd5, "R6 ix after exchange", 16'hBEEF);
    rd_pair(3'd7, "R6 page/refresh after exchange", 16'h4321);

    // R7 refresh
    do_reset();
    pwr(3'd7, 16'h127E); tick();
    fetch_tick = 1; tick();
    rd_pair(3'd7, "R7 increment", 16'h127F);
    fetch_tick = 1; tick();
    rd_pair(3'd7, "R7 wrap low bits", 16'h1200);
    pwr(3'd7, 16'h12FF); tick();
    fetch_tick = 1; tick();
    rd_pair(3'd7, "R7 bit7 held", 16'h1280);

    // R8 write beats fetch
    pwr(3'd7, 16'h3405); fetch_tick = 1; tick();
    rd_pair(3'd7, "R8 write wins", 16'h3405);

    // R10 collisions
    pwr(3'd0, 16'h7788); bw_en = 1; bw_sel = 3'd0; bw_data = 8'h99; tick();
    rd_pair(3'd0, "R10 pair beats byte", 16'h7788);
    pwr(3'd1, 16'hCAFE); xchg_gen = 1; tick();
    rd_pair(3'd1, "R10 write with exchange hidden", 16'h0000);
    xchg_gen = 1; tick();
    rd_pair(3'd1, "R10 write went to old bank", 16'hCAFE);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule